// File: doc/BRIEF.md
# Dithered Video Output Formatter

This block sits at the output end of a video processing path. It takes luminance and chroma samples that carry two fractional bits below the 8-bit LSB and turns them into an output bus. Each lane can be 8 bits wide, or 9 bits wide with one fractional bit. A write strobe marks the words that carry data. In 8-bit mode, the value can be reduced either by plain rounding or by dithered rounding. Dithered rounding adds a quarter LSB on odd-numbered samples of a line and three quarters on even-numbered ones. The DC level is kept on average, and low-frequency content gains about one bit of resolution. The dither pattern can be flipped by 180 degrees on every line, every field or every frame, which hides the fixed pattern.

The strobe works as a qualifier, rising with the first word, or as a prequalifier, rising one clock earlier. A small state machine drives it through four states:
- ST_IDLE: strobe low.
- ST_WAIT: qualifier mode, one cycle while the first word is in the pipeline, strobe low.
- ST_LEAD: prequalifier mode, the early strobe cycle, strobe high.
- ST_RUN: strobe high while data words are presented.

The transitions are:
- IDLE to WAIT: a burst starts in qualifier mode.
- IDLE to LEAD: a burst starts in prequalifier mode.
- WAIT to RUN, and LEAD to RUN: always, one cycle later.
- RUN to RUN: while the burst is still feeding words into the pipeline.
- RUN to IDLE: once the last word has been shown.

Output bits that are not used are put in high impedance. These are the low bit of each lane in 8-bit mode, the four low chroma bits in 4:1:1 mode, and the strobe when it is not used. Filtering and subsampling happen upstream.

Top module: `dither_out_fmt`

## Requirements
- R1: After reset the strobe output is low (when enabled), and the state machine is in ST_IDLE.
- R2: With dithering off and 8-bit mode, each lane outputs min(255, (x+2)>>2) on bits 8..1, where x is the 10-bit input. Bit 0 is high impedance.
- R3: With dithering on and 8-bit mode, the n-th sample of a line (counting from 1) adds 1 when n is odd and 3 when n is even, before the result is shifted right by 2 and saturated at 255. Luminance and chroma use the same offset.
- R4: The sample count of R3 restarts at each line_start pulse. Markers only arrive while act is low.
- R5: flip_sel picks the event that toggles the dither phase: 0 never, 1 line_start, 2 field_start, 3 frame_start. While the phase is toggled, the odd and even offsets of R3 swap. The phase is untoggled after reset.
- R6: In 9-bit mode (wide9=1), each lane outputs min(511, (x+1)>>1) on all 9 bits, and no dither is added.
- R7: With preq=0, the strobe rises in the same cycle as the first data word. That word is visible after the second clock edge that sampled act high.
- R8: With preq=1, the strobe rises one cycle before the first data word.
- R9: The strobe falls right after the last word of a burst. Bursts are separated by at least two cycles with act low.
- R10: With fmt411=1, chroma bits 3..0 are high impedance, and luminance is unaffected.
- R11: With we_oe=0, the strobe output is high impedance.
- R12: Words appear two clock edges after their input sample, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act | input | 1 | Input sample valid (active video) |
| y_in | input | 10 | Luminance sample, 8 integer + 2 fractional bits |
| c_in | input | 10 | Multiplexed chroma sample, same scale |
| line_start | input | 1 | Line start pulse |
| field_start | input | 1 | Field start pulse |
| frame_start | input | 1 | Frame start pulse |
| dith_en | input | 1 | Dithered rounding in 8-bit mode |
| flip_sel | input | 2 | Dither phase flip event select |
| wide9 | input | 1 | 9-bit output mode |
| fmt411 | input | 1 | 4:1:1 output (chroma low bits released) |
| preq | input | 1 | Prequalifier strobe mode |
| we_oe | input | 1 | Strobe output enable |
| y_out | output | 9 | Luminance output lane |
| c_out | output | 9 | Chroma output lane |
| we_out | output | 1 | Write strobe |

## Verification
The checks on the state machine assume that act bursts are separated by at least two low cycles. They also assume that line, field and frame markers arrive only while act is low, and that mode inputs change only between bursts. The checker asserts the first two of these. The random stimulus builds every burst from a task that always inserts a four-cycle gap and drives markers and mode changes only in that gap. Burst lengths, sample values and modes are randomized. Directed bursts hit the saturation edges at codes 1021 to 1023 and both flip polarities.

// File: rtl/dither_out_fmt_pkg.sv
package dither_out_fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LEAD = 2'd2,
        ST_RUN  = 2'd3
    } strobe_st_e;

    typedef enum logic [1:0] {
        FLIP_NONE  = 2'd0,
        FLIP_LINE  = 2'd1,
        FLIP_FIELD = 2'd2,
        FLIP_FRAME = 2'd3
    } flip_sel_e;

endpackage

// File: rtl/dither_out_fmt_quant.sv
module dither_out_fmt_quant #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 2,
    localparam int IN_W   = INT_W + FRAC_W,
    localparam int LANE_W = INT_W + 1
) (
    input  logic [IN_W-1:0]   x,
    input  logic              dith_en,
    input  logic              use_hi,
    input  logic              wide9,
    output logic [LANE_W-1:0] q
);
    localparam int SUM_W = IN_W + 1;
    localparam logic [SUM_W-1:0] QTR  = SUM_W'(1) << (FRAC_W - 2);
    localparam logic [SUM_W-1:0] HALF = QTR << 1;
    localparam logic [SUM_W-1:0] HI3  = QTR * 3;
    localparam logic [INT_W-1:0]  MAX8 = '1;
    localparam logic [LANE_W-1:0] MAX9 = '1;

    logic [SUM_W-1:0] off8, sum8, sum9;
    logic [SUM_W-1:0] sh8, sh9;

    always_comb begin
        if (dith_en) off8 = use_hi ? HI3 : QTR;
        else         off8 = HALF;
        sum8 = SUM_W'(x) + off8;
        sum9 = SUM_W'(x) + QTR;
        sh8  = sum8 >> FRAC_W;
        sh9  = sum9 >> (FRAC_W - 1);
        if (wide9) begin
            q = (sh9 > SUM_W'(MAX9)) ? MAX9 : sh9[LANE_W-1:0];
        end else begin
            q = {((sh8 > SUM_W'(MAX8)) ? MAX8 : sh8[INT_W-1:0]), 1'b0};
        end
    end
endmodule

// File: rtl/dither_out_fmt_phase.sv
module dither_out_fmt_phase
    import dither_out_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act,
    input  logic       line_start,
    input  logic       field_start,
    input  logic       frame_start,
    input  logic [1:0] flip_sel,
    output logic       use_hi
);
    logic par_q, flip_q, flip_evt;

    always_comb begin
        unique case (flip_sel_e'(flip_sel))
            FLIP_NONE:  flip_evt = 1'b0;
            FLIP_LINE:  flip_evt = line_start;
            FLIP_FIELD: flip_evt = field_start;
            FLIP_FRAME: flip_evt = frame_start;
            default:    flip_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q  <= 1'b0;
            flip_q <= 1'b0;
        end else begin
            if (line_start) par_q <= 1'b0;
            else if (act)   par_q <= ~par_q;
            if (flip_evt)   flip_q <= ~flip_q;
        end
    end

    assign use_hi = par_q ^ flip_q;
endmodule

// File: rtl/dither_out_fmt_strobe.sv
module dither_out_fmt_strobe
    import dither_out_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act,
    input  logic       preq,
    output strobe_st_e st_q,
    output logic       we_int
);
    strobe_st_e st_d;
    logic       act_d1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            act_d1 <= 1'b0;
        end else begin
            st_q   <= st_d;
            act_d1 <= act;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (act) st_d = preq ? ST_LEAD : ST_WAIT;
            ST_WAIT: st_d = ST_RUN;
            ST_LEAD: st_d = ST_RUN;
            ST_RUN:  st_d = act_d1 ? ST_RUN : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: we_int = 1'b0;
            ST_WAIT: we_int = 1'b0;
            ST_LEAD: we_int = 1'b1;
            ST_RUN:  we_int = 1'b1;
            default: we_int = 1'b0;
        endcase
    end
endmodule

// File: rtl/dither_out_fmt.sv
module dither_out_fmt
    import dither_out_fmt_pkg::*;
#(
    parameter int INT_W    = 8,
    parameter int FRAC_W   = 2,
    parameter int C411_LOW = 4,
    localparam int IN_W   = INT_W + FRAC_W,
    localparam int LANE_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic [IN_W-1:0]   y_in,
    input  logic [IN_W-1:0]   c_in,
    input  logic              line_start,
    input  logic              field_start,
    input  logic              frame_start,
    input  logic              dith_en,
    input  logic [1:0]        flip_sel,
    input  logic              wide9,
    input  logic              fmt411,
    input  logic              preq,
    input  logic              we_oe,
    output logic [LANE_W-1:0] y_out,
    output logic [LANE_W-1:0] c_out,
    output logic              we_out
);
    strobe_st_e        st_q;
    logic              we_int;
    logic              use_hi, hi_s1, v_s1;
    logic [IN_W-1:0]   y_s1, c_s1;
    logic [LANE_W-1:0] y_qd, c_qd, y_q, c_q;
    logic [LANE_W-1:0] y_oe, c_oe;

    dither_out_fmt_phase u_phase (
        .clk(clk), .rst_n(rst_n), .act(act),
        .line_start(line_start), .field_start(field_start),
        .frame_start(frame_start), .flip_sel(flip_sel), .use_hi(use_hi)
    );

    dither_out_fmt_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .act(act), .preq(preq),
        .st_q(st_q), .we_int(we_int)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_s1  <= '0;
            c_s1  <= '0;
            hi_s1 <= 1'b0;
            v_s1  <= 1'b0;
            y_q   <= '0;
            c_q   <= '0;
        end else begin
            v_s1 <= act;
            if (act) begin
                y_s1  <= y_in;
                c_s1  <= c_in;
                hi_s1 <= use_hi;
            end
            if (v_s1) begin
                y_q <= y_qd;
                c_q <= c_qd;
            end
        end
    end

    dither_out_fmt_quant #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_qy (
        .x(y_s1), .dith_en(dith_en), .use_hi(hi_s1), .wide9(wide9), .q(y_qd)
    );
    dither_out_fmt_quant #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_qc (
        .x(c_s1), .dith_en(dith_en), .use_hi(hi_s1), .wide9(wide9), .q(c_qd)
    );

    generate
        for (genvar b = 0; b < LANE_W; b++) begin : g_lane
            if (b == 0) begin : g_lsb
                assign y_oe[b] = wide9;
                assign c_oe[b] = wide9 && !fmt411;
            end else if (b < C411_LOW) begin : g_low
                assign y_oe[b] = 1'b1;
                assign c_oe[b] = !fmt411;
            end else begin : g_high
                assign y_oe[b] = 1'b1;
                assign c_oe[b] = 1'b1;
            end
            assign y_out[b] = y_oe[b] ? y_q[b] : 1'bz;
            assign c_out[b] = c_oe[b] ? c_q[b] : 1'bz;
        end
    endgenerate

    assign we_out = we_oe ? we_int : 1'bz;
endmodule

// File: rtl/dither_out_fmt_chk.sv
module dither_out_fmt_chk
    import dither_out_fmt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       act,
    input logic       line_start,
    input logic       field_start,
    input logic       frame_start,
    input logic       preq,
    input strobe_st_e st,
    input logic       we_int
);
    AST_QUAL_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && act && !preq) |=> !we_int);  // R7
    AST_QUAL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && act && !preq) |=> ##1 we_int);  // R7
    AST_PREQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && act && preq) |=> we_int);  // R8
    AST_WE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_int) |-> !$past(act, 2));  // R9
    AST_BURST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act) |=> !act);  // R9
    AST_MARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || field_start || frame_start) |-> !act);  // R4
endmodule

bind dither_out_fmt dither_out_fmt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .act(act), .line_start(line_start),
    .field_start(field_start), .frame_start(frame_start), .preq(preq),
    .st(st_q), .we_int(we_int)
);

// File: tb/dither_out_fmt_test.sv
`timescale 1ns/1ps
module dither_out_fmt_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act = 1'b0;
    logic [9:0] y_in = '0, c_in = '0;
    logic line_start = 1'b0, field_start = 1'b0, frame_start = 1'b0;
    logic dith_en = 1'b0, wide9 = 1'b0, fmt411 = 1'b0, preq = 1'b0, we_oe = 1'b1;
    logic [1:0] flip_sel = 2'd0;
    wire [8:0] y_out, c_out;
    wire we_out;

    int checks = 0, errors = 0;
    bit done = 0;
    int line_cnt = 0;
    bit flip_m = 0;
    int unsigned seed_dummy;

    always #2.5 clk = ~clk;

    dither_out_fmt uut (
        .clk(clk), .rst_n(rst_n), .act(act), .y_in(y_in), .c_in(c_in),
        .line_start(line_start), .field_start(field_start), .frame_start(frame_start),
        .dith_en(dith_en), .flip_sel(flip_sel), .wide9(wide9), .fmt411(fmt411),
        .preq(preq), .we_oe(we_oe), .y_out(y_out), .c_out(c_out), .we_out(we_out)
    );

    function automatic logic [8:0] exp_lane(input logic [9:0] x, input bit hi, input bit chroma);
        int s;
        logic [8:0] r;
        if (wide9) begin
            s = (int'(x) + 1) >> 1;
            if (s > 511) s = 511;
            r = 9'(s);
        end else begin
            s = (int'(x) + (dith_en ? (hi ? 3 : 1) : 2)) >> 2;
            if (s > 255) s = 255;
            r = {8'(s), 1'bz};
        end
        if (chroma && fmt411) r[3:0] = 4'bzzzz;
        return r;
    endfunction

    task automatic check_bit(input logic act_v, input logic exp_v, input string req);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act_v, exp_v);
        end
    endtask

    task automatic check_vec(input logic [8:0] act_v, input logic [8:0] exp_v, input string req);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act_v, exp_v);
        end
    endtask

    task automatic marker(input int which);
        @(negedge clk);
        case (which)
            0: begin line_start = 1; line_cnt = 0; if (flip_sel == 2'd1) flip_m = ~flip_m; end
            1: begin field_start = 1; if (flip_sel == 2'd2) flip_m = ~flip_m; end
            default: begin frame_start = 1; if (flip_sel == 2'd3) flip_m = ~flip_m; end
        endcase
        @(negedge clk);
        line_start = 0; field_start = 0; frame_start = 0;
    endtask

    // Drives one burst; directed values used when dir_n > 0
    task automatic burst(input int len, input int dir_n, input logic [9:0] dv [0:7]);
        logic [8:0] ey [0:63];
        logic [8:0] ec [0:63];
        bit we_exp;
        string rq;
        for (int j = 0; j <= len + 3; j++) begin
            @(negedge clk);
            // check outputs from the previous edge
            if (!we_oe) check_bit(we_out, 1'bz, "R11");
            else begin
                we_exp = preq ? (j >= 1 && j <= len + 1) : (j >= 2 && j <= len + 1);
                check_bit(we_out, we_exp, preq ? "R8/R9" : "R7/R9");
            end
            if (j >= 2 && j - 2 < len) begin
                rq = wide9 ? "R6/R12" : (dith_en ? "R3/R5" : "R2/R12");
                check_vec(y_out, ey[j-2], rq);
                check_vec(c_out, ec[j-2], fmt411 ? "R10" : rq);
            end
            if (j < len) begin
                act = 1;
                y_in = (j < dir_n) ? dv[j] : 10'($urandom_range(0, 1023));
                c_in = (j < dir_n) ? ~dv[j] : 10'($urandom_range(0, 1023));
                ey[j] = exp_lane(y_in, ((line_cnt % 2) == 1) ^ flip_m, 0);
                ec[j] = exp_lane(c_in, ((line_cnt % 2) == 1) ^ flip_m, 1);
                line_cnt++;
            end else act = 0;
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] dv [0:7];
        seed_dummy = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        check_bit(we_out, 1'b0, "R1");
        rst_n = 1;
        @(negedge clk);
        check_bit(we_out, 1'b0, "R1");

        // R2: plain rounding, saturation edges
        dv = '{10'd0, 10'd1, 10'd2, 10'd5, 10'd1021, 10'd1022, 10'd1023, 10'd6};
        marker(0);
        burst(8, 8, dv);

        // R3/R4: dithered rounding, restart count at each line
        dith_en = 1;
        dv = '{10'd1, 10'd1, 10'd2, 10'd2, 10'd1020, 10'd1021, 10'd1023, 10'd1023};
        marker(0);
        burst(8, 8, dv);
        burst(3, 3, dv);
        marker(0);
        burst(5, 5, dv);

        // R5: flip on line, field, frame
        for (int s = 1; s <= 3; s++) begin
            flip_sel = 2'(s);
            for (int k = 0; k < 3; k++) begin
                marker(k);
                marker(0);
                burst(4, 4, dv);
            end
        end
        flip_sel = 0;

        // R6: 9-bit mode
        wide9 = 1;
        dv = '{10'd0, 10'd1, 10'd2, 10'd3, 10'd1021, 10'd1022, 10'd1023, 10'd511};
        burst(8, 8, dv);

        // R8: prequalifier, single-word burst
        preq = 1;
        burst(1, 1, dv);
        burst(6, 0, dv);

        // R10, R11
        fmt411 = 1; wide9 = 0;
        burst(4, 0, dv);
        we_oe = 0;
        burst(3, 0, dv);
        we_oe = 1; fmt411 = 0; preq = 0;

        // random mix
        for (int n = 0; n < 60; n++) begin
            dith_en  = 1'($urandom_range(0, 1));
            wide9    = 1'($urandom_range(0, 1));
            fmt411   = 1'($urandom_range(0, 1));
            preq     = 1'($urandom_range(0, 1));
            we_oe    = ($urandom_range(0, 7) != 0);
            flip_sel = 2'($urandom_range(0, 3));
            marker($urandom_range(0, 2));
            if ($urandom_range(0, 1) == 1) marker(0);
            burst($urandom_range(1, 40), 0, dv);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule